// File: doc/BRIEF.md
# Per-Spill Trigger Scaler Bank

This block keeps rate statistics for a trigger system over each beam spill. It holds two banks of counters: one bank counts trigger pulses before they are downscaled, the other counts the same trigger lines after downscaling and busy gating. Each channel is driven by a single-cycle count-enable line, so a count of one per clock cycle is the highest rate a channel can reach.

When the shaped spill-start pulse arrives, every counter value is copied into its own holding register and the counter is cleared, in the same clock edge. The holding registers keep the totals of the finished spill until the next spill-start. A counter never wraps: it stops at its maximum value. The spill-start pulse is used only here and plays no part in the fast trigger path.

A plain synchronous read port stands in for the host bus. It takes a word address and returns the selected holding register one cycle later.

Top module: `spill_scaler_bank`

## Requirements
- R1: While `rst_ni` is low, all counters, all holding registers and `rd_data_o` are cleared to zero.
- R2: In each clock cycle without a spill-start, a high `pre_inc_i[k]` adds one to pre-downscale counter k, and a high `post_inc_i[k]` adds one to post-downscale counter k.
- R3: On a clock edge where `spill_i` is high, every one of the 16 holding registers takes the value its counter held just before that edge.
- R4: On a spill-start edge, a counter whose enable is low becomes 0.
- R5: On a spill-start edge, a counter whose enable is high becomes 1, so that increment counts toward the new spill.
- R6: A counter saturates at 2^W-1 and does not wrap. W is `PRE_W` (default 32) for the pre-downscale bank and `POST_W` (default 16) for the post-downscale bank.
- R7: Holding registers keep their value on every edge without a spill-start, whatever the enables do.
- R8: Read map with the default 5-bit address: words 0 to 7 return pre-downscale holding registers 0 to 7. Words 8 to 15 return post-downscale holding registers 0 to 7, zero-extended. Words 16 to 31 return zero.
- R9: `rd_data_o` is registered. It shows the word for the address sampled on the previous clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scaler clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_inc_i | input | N_CH | Count enables, triggers before downscaling |
| post_inc_i | input | N_CH | Count enables, triggers after downscaling |
| spill_i | input | 1 | Shaped single-cycle spill-start pulse |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | DATA_W | Read data, max(PRE_W, POST_W) bits |

## Verification
Counter state is only visible through the holding registers. A wrong count, a missed clear or a lost coincident increment therefore appears at the read port only after the next spill-start has copied it out, one cycle after the matching address is presented. A holding register that changes outside a spill shows up as soon as it is re-read without an intervening spill. Saturation is checked with reduced counter widths, so that the ceiling can be reached in a short run.

// File: rtl/spill_scaler_pkg.sv
package spill_scaler_pkg;
  localparam int unsigned DEF_N_CH   = 8;
  localparam int unsigned DEF_PRE_W  = 32;
  localparam int unsigned DEF_POST_W = 16;
  localparam int unsigned DEF_ADDR_W = 5;

  typedef enum logic [1:0] {
    SEL_PRE  = 2'd0,
    SEL_POST = 2'd1,
    SEL_NONE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/scaler_cell.sv
module scaler_cell #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         spill_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] cnt_q, cnt_d, hold_q;
  logic         sat;

  assign sat = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (spill_i) begin
      // increment coincident with spill start belongs to the new spill
      cnt_d = inc_i ? W'(1) : '0;
    end else if (inc_i && !sat) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (spill_i) hold_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         inc_i,
  input  logic                 spill_i,
  output logic [N-1:0][W-1:0]  cnt_o,
  output logic [N-1:0][W-1:0]  hold_o
);
  for (genvar k = 0; k < N; k++) begin : g_ch
    scaler_cell #(.W(W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_i[k]),
      .spill_i(spill_i),
      .cnt_o  (cnt_o[k]),
      .hold_o (hold_o[k])
    );
  end
endmodule

// File: rtl/scaler_rd_port.sv
module scaler_rd_port
  import spill_scaler_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned PRE_W  = 32,
  parameter int unsigned POST_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic [N-1:0][PRE_W-1:0]  pre_hold_i,
  input  logic [N-1:0][POST_W-1:0] post_hold_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int unsigned CH_W = (N > 1) ? $clog2(N) : 1;

  rd_sel_e             sel;
  logic [CH_W-1:0]     ch;
  logic [ADDR_W-1:0]   hi_bits;
  logic [DATA_W-1:0]   word;
  logic [DATA_W-1:0]   rd_q;

  assign ch      = rd_addr_i[CH_W-1:0];
  assign hi_bits = rd_addr_i >> (CH_W + 1);

  always_comb begin
    if (hi_bits != '0)         sel = SEL_NONE;
    else if (rd_addr_i[CH_W])  sel = SEL_POST;
    else                       sel = SEL_PRE;
  end

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_PRE:  word[PRE_W-1:0]  = pre_hold_i[ch];
      SEL_POST: word[POST_W-1:0] = post_hold_i[ch];
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= word;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/spill_scaler_bank.sv
module spill_scaler_bank
  import spill_scaler_pkg::*;
#(
  parameter int unsigned N_CH   = DEF_N_CH,
  parameter int unsigned PRE_W  = DEF_PRE_W,
  parameter int unsigned POST_W = DEF_POST_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned DATA_W = (PRE_W > POST_W) ? PRE_W : POST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   pre_inc_i,
  input  logic [N_CH-1:0]   post_inc_i,
  input  logic              spill_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [N_CH-1:0][PRE_W-1:0]  pre_cnt, pre_hold;
  logic [N_CH-1:0][POST_W-1:0] post_cnt, post_hold;

  scaler_bank #(.N(N_CH), .W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (pre_inc_i),
    .spill_i(spill_i),
    .cnt_o  (pre_cnt),
    .hold_o (pre_hold)
  );

  scaler_bank #(.N(N_CH), .W(POST_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (post_inc_i),
    .spill_i(spill_i),
    .cnt_o  (post_cnt),
    .hold_o (post_hold)
  );

  scaler_rd_port #(
    .N(N_CH), .PRE_W(PRE_W), .POST_W(POST_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr_i),
    .pre_hold_i (pre_hold),
    .post_hold_i(post_hold),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/spill_scaler_chk.sv
module spill_scaler_chk #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PRE_W  = 32,
  parameter int unsigned POST_W = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_CH-1:0]             pre_inc_i,
  input logic [N_CH-1:0]             post_inc_i,
  input logic                        spill_i,
  input logic [ADDR_W-1:0]           rd_addr_i,
  input logic [DATA_W-1:0]           rd_data_o,
  input logic [N_CH-1:0][PRE_W-1:0]  pre_cnt,
  input logic [N_CH-1:0][PRE_W-1:0]  pre_hold,
  input logic [N_CH-1:0][POST_W-1:0] post_cnt,
  input logic [N_CH-1:0][POST_W-1:0] post_hold
);
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  always_comb begin
    // R1
    if (!rst_ni) begin
      rst_clear_chk: assert (rd_data_o == '0);
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    // R2
    pre_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spill_i && pre_inc_i[k] && !(&pre_cnt[k])) |=> pre_cnt[k] == $past(pre_cnt[k]) + PRE_W'(1));
    // R2
    post_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spill_i && post_inc_i[k] && !(&post_cnt[k])) |=> post_cnt[k] == $past(post_cnt[k]) + POST_W'(1));
    // R3
    pre_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spill_i |=> pre_hold[k] == $past(pre_cnt[k]));
    // R3
    post_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spill_i |=> post_hold[k] == $past(post_cnt[k]));
    // R4
    pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spill_i && !pre_inc_i[k]) |=> pre_cnt[k] == '0);
    // R5
    pre_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spill_i && pre_inc_i[k]) |=> pre_cnt[k] == PRE_W'(1));
    // R6
    post_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spill_i && (&post_cnt[k])) |=> (&post_cnt[k]));
    // R6
    pre_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spill_i && (&pre_cnt[k])) |=> (&pre_cnt[k]));
    // R7
    hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !spill_i |=> ($stable(pre_hold[k]) && $stable(post_hold[k])));
  end

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_addr_i >> (CH_W + 1)) != '0) |=> rd_data_o == '0);
endmodule

bind spill_scaler_bank spill_scaler_chk #(
  .N_CH(N_CH), .PRE_W(PRE_W), .POST_W(POST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pre_inc_i(pre_inc_i), .post_inc_i(post_inc_i),
  .spill_i(spill_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .pre_cnt(pre_cnt), .pre_hold(pre_hold), .post_cnt(post_cnt), .post_hold(post_hold)
);

// File: tb/spill_scaler_bank_tb.sv
module spill_scaler_bank_tb;
  localparam int unsigned N_CH   = 8;
  localparam int unsigned PRE_W  = 10;
  localparam int unsigned POST_W = 6;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 10;
  localparam int PRE_MAX  = (1 << PRE_W) - 1;
  localparam int POST_MAX = (1 << POST_W) - 1;

  // {pre enables, post enables, cycles}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'h00, 8'd5},
    {8'h01, 8'h80, 8'd3},
    {8'hA5, 8'h5A, 8'd7},
    {8'h00, 8'hFF, 8'd2},
    {8'h3C, 8'hC3, 8'd11},
    {8'h80, 8'h01, 8'd1}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_CH-1:0]   pre_inc = '0, post_inc = '0;
  logic              spill = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;

  int total = 0, bad = 0;
  int cnt_pre [N_CH], hold_pre [N_CH], cnt_post [N_CH], hold_post [N_CH];

  always #2.5 clk = ~clk;

  spill_scaler_bank #(
    .N_CH(N_CH), .PRE_W(PRE_W), .POST_W(POST_W), .ADDR_W(ADDR_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pre_inc_i(pre_inc), .post_inc_i(post_inc),
    .spill_i(spill), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] pe, input logic [7:0] po, input logic sp);
    @(negedge clk);
    pre_inc = pe; post_inc = po; spill = sp;
    for (int k = 0; k < N_CH; k++) begin
      if (sp) begin
        hold_pre[k]  = cnt_pre[k];  cnt_pre[k]  = pe[k] ? 1 : 0;
        hold_post[k] = cnt_post[k]; cnt_post[k] = po[k] ? 1 : 0;
      end else begin
        if (pe[k] && cnt_pre[k]  < PRE_MAX)  cnt_pre[k]++;
        if (po[k] && cnt_post[k] < POST_MAX) cnt_post[k]++;
      end
    end
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    pre_inc = '0; post_inc = '0; spill = 1'b0; rd_addr = ADDR_W'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic check_all(input string req);
    int d;
    for (int a = 0; a < 2 * N_CH; a++) begin
      rd(a, d);
      check(req, d, (a < N_CH) ? hold_pre[a] : hold_post[a - N_CH]);
    end
  endtask

  initial begin
    int d;
    for (int k = 0; k < N_CH; k++) begin
      cnt_pre[k] = 0; hold_pre[k] = 0; cnt_post[k] = 0; hold_post[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data in reset", int'(rd_data), 0);
    rst_ni = 1'b1;
    rd(0, d);  check("R1 pre hold after reset", d, 0);
    rd(8, d);  check("R1 post hold after reset", d, 0);
    rd(15, d); check("R1 post hold7 after reset", d, 0);

    // R2 R3: vector table
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++) step(VEC[v][23:16], VEC[v][15:8], 1'b0);
      step(8'h00, 8'h00, 1'b1);
      check_all("R2 R3 vector counts");
    end

    // R5 and R4: coincident increment on ch2, none on ch3
    for (int c = 0; c < 4; c++) step(8'h0C, 8'h04, 1'b0);
    step(8'h04, 8'h04, 1'b1);
    rd(2, d);  check("R3 pre ch2 latched", d, 4);
    rd(3, d);  check("R3 pre ch3 latched", d, 4);
    step(8'h00, 8'h00, 1'b1);
    rd(2, d);  check("R5 pre ch2 carried into new spill", d, 1);
    rd(3, d);  check("R4 pre ch3 cleared", d, 0);
    rd(10, d); check("R5 post ch2 carried into new spill", d, 1);

    // R7: counting without spill leaves holds untouched
    for (int c = 0; c < 6; c++) step(8'hFF, 8'hFF, 1'b0);
    check_all("R7 holds stable");

    // R6: saturation
    step(8'h00, 8'h00, 1'b1);
    for (int c = 0; c < 70; c++) step(8'h00, 8'hFF, 1'b0);
    for (int c = 0; c < 1030; c++) step(8'h01, 8'h00, 1'b0);
    step(8'h00, 8'h00, 1'b1);
    rd(0, d);  check("R6 pre saturates", d, PRE_MAX);
    rd(9, d);  check("R6 post saturates", d, POST_MAX);
    check_all("R6 bank after saturation");

    // R8: unmapped words read zero
    rd(16, d); check("R8 addr 16 zero", d, 0);
    rd(23, d); check("R8 addr 23 zero", d, 0);
    rd(31, d); check("R8 addr 31 zero", d, 0);

    // R9: registered read, one cycle latency
    rd(0, d);
    @(negedge clk); rd_addr = 5'd3;
    #1 check("R9 no change before edge", int'(rd_data), PRE_MAX);
    @(negedge clk);
    check("R9 new word after one edge", int'(rd_data), hold_pre[3]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule